// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and a byte-wide asynchronous static RAM. The RAM has an active-low and an active-high chip select, active-low write and output enables, an 18-bit address and an 8-bit data bus. The host offers one request at a time over a valid/ready handshake: address, write data and a write flag. The controller turns each request into a strobe sequence whose every phase lasts a whole number of clock cycles. Each phase length is derived at elaboration from nanosecond minimums and a clock-period parameter, always rounding up.

A speed-grade parameter selects one of two timing sets. The fast set uses 70 ns access, 70 ns cycle, 50 ns write pulse, 30 ns data setup and 60 ns select-to-end-of-write. The slow set uses 85, 85, 60, 35 and 70 ns. Read data is sampled into a register and announced with a one-cycle valid pulse. The data bus is split into an output value, an output enable and an input value, so the tri-state buffer itself sits at the pad.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, mem_sel_n=1, mem_sel=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, rd_valid=0 and req_ready=1.
- R2: A read holds mem_sel_n=0, mem_sel=1, mem_we_n=1 and mem_oe_n=0 for ACC = ceil(max(access, read cycle)/clock) cycles, which is 14 at the fast grade and 5 ns clock. It samples mem_dq_in at the edge that ends the last of those cycles and presents that byte on rd_data.
- R3: A write selects the chip with mem_we_n=1 for one cycle. It then holds mem_we_n=0 for P = max(ceil(pulse), ceil(data setup), ceil(select-to-end)-1) cycles, which is 11 at the fast grade. It then keeps the chip selected with mem_we_n=1 for REC = max(1, ceil(write cycle)-1-P) cycles, which is 2. The whole write occupies 1+P+REC = 14 cycles, and chip select is active for at least ceil(select-to-end) = 12 cycles when mem_we_n rises.
- R4: mem_dq_oe is 1 in exactly the P+REC cycles of write pulse and recovery (13). It is 1 whenever mem_we_n=0, and mem_dq_out holds the request's write data unchanged across the pulse.
- R5: mem_dq_oe=1 never coincides with mem_oe_n=0. After a read, mem_oe_n stays high for at least TURN = max(1, ceil(turnaround/clock)) cycles, which is 5 for 25 ns, before mem_dq_oe can rise. A read therefore occupies ACC+TURN = 19 cycles from acceptance to the return of req_ready.
- R6: mem_addr does not change while the chip stays selected across consecutive cycles. It changes only at the edge that accepts a request.
- R7: req_ready is 1 only while the controller is idle. A request held valid while busy is not taken until req_ready returns, and is then taken at the next edge.
- R8: rd_valid pulses for exactly one cycle per read, in the cycle right after the sampling edge. It never pulses for a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request will be taken at the next edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Request byte address |
| req_wdata | input | 8 | Request write data |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a fresh read byte |
| rd_data | output | 8 | Last byte read |
| mem_addr | output | 18 | RAM address |
| mem_sel_n | output | 1 | RAM chip select, active low |
| mem_sel | output | 1 | RAM chip select, active high |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 8 | Data arriving from the RAM |

## Verification
Two things can land in the same cycle: the return of read data with its rd_valid pulse, and a new host request that is already waiting. The bench provokes this by holding a write request valid from the cycle after a read is accepted. It then judges that the request is ignored through the whole access and turnaround, with mem_addr fixed to the read address, and that it is accepted one edge after req_ready returns. It also checks that the read byte is neither lost nor overwritten, and that the following write keeps the bus-turnaround gap. A RAM model in the bench serves reads only after the access time counted in clock cycles and stores data on the rising write enable, so short phases show up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_REL,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_REC
  } seq_state_e;

  // round a nanosecond minimum up to whole clock cycles
  function automatic int ns_to_cyc(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PS     = 5000,
  parameter bit FAST_GRADE = 1'b1,
  parameter int TURN_NS    = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_wr,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       cap_en
);

  // timing set chosen by grade
  localparam int AA_NS = FAST_GRADE ? 70 : 85;
  localparam int RC_NS = FAST_GRADE ? 70 : 85;
  localparam int WP_NS = FAST_GRADE ? 50 : 60;
  localparam int DW_NS = FAST_GRADE ? 30 : 35;
  localparam int AW_NS = FAST_GRADE ? 60 : 70;
  localparam int WC_NS = FAST_GRADE ? 70 : 85;

  localparam int RD_C   = imax(ns_to_cyc(AA_NS, CLK_PS), ns_to_cyc(RC_NS, CLK_PS));
  localparam int P_C    = imax(imax(ns_to_cyc(WP_NS, CLK_PS), ns_to_cyc(DW_NS, CLK_PS)),
                               ns_to_cyc(AW_NS, CLK_PS) - 1);
  localparam int REC_C  = imax(1, ns_to_cyc(WC_NS, CLK_PS) - 1 - P_C);
  localparam int TURN_C = imax(1, ns_to_cyc(TURN_NS, CLK_PS));
  localparam int MAX_C  = imax(imax(RD_C, P_C), imax(REC_C, TURN_C));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_C - 1);
  localparam logic [CNT_W-1:0] P_LAST    = CNT_W'(P_C - 1);
  localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_C - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_C - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + CNT_W'(1);
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start) state_d = start_wr ? ST_WR_SET : ST_RD_ACC;
      end
      ST_RD_ACC: if (cnt_q == RD_LAST) begin
        state_d = ST_RD_REL;
        cnt_d   = '0;
      end
      ST_RD_REL: if (cnt_q == TURN_LAST) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      ST_WR_SET: begin
        state_d = ST_WR_PULSE;
        cnt_d   = '0;
      end
      ST_WR_PULSE: if (cnt_q == P_LAST) begin
        state_d = ST_WR_REC;
        cnt_d   = '0;
      end
      ST_WR_REC: if (cnt_q == REC_LAST) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  assign cap_en = (state_q == ST_RD_ACC) && (cnt_q == RD_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3: a write pulse is always entered from the select-only setup cycle
  p_pulse_after_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_PULSE && $past(state_q) != ST_WR_PULSE) |-> $past(state_q) == ST_WR_SET);

  // R2: the counter never runs past the access window
  p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACC) |-> (cnt_q <= RD_LAST));

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_d,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  logic sel_on, oe_on, we_on, drv_on;

  // strobes are registered from the next state, so they change with it
  always_comb begin
    sel_on = (state_d == ST_RD_ACC) || (state_d == ST_WR_SET) ||
             (state_d == ST_WR_PULSE) || (state_d == ST_WR_REC);
    oe_on  = (state_d == ST_RD_ACC);
    we_on  = (state_d == ST_WR_PULSE);
    drv_on = (state_d == ST_WR_PULSE) || (state_d == ST_WR_REC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_sel_n <= 1'b1;
      mem_sel   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_sel_n <= !sel_on;
      mem_sel   <= sel_on;
      mem_we_n  <= !we_on;
      mem_oe_n  <= !oe_on;
      mem_dq_oe <= drv_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (load) begin
      mem_addr   <= addr_in;
      mem_dq_out <= wdata_in;
    end
  end

  p_no_bus_clash_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

  p_we_inside_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel));

  p_dq_with_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && $stable(mem_dq_out)));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= dq_in;
    end
  end

  p_rdv_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int CLK_PS     = 5000,
  parameter bit FAST_GRADE = 1'b1,
  parameter int TURN_NS    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  seq_state_e state_q, state_d;
  logic       cap_en;
  logic       accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_seq_fsm #(
    .CLK_PS     (CLK_PS),
    .FAST_GRADE (FAST_GRADE),
    .TURN_NS    (TURN_NS)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .state_q  (state_q),
    .state_d  (state_d),
    .cap_en   (cap_en)
  );

  sram_pin_drv #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_d    (state_d),
    .load       (accept),
    .addr_in    (req_addr),
    .wdata_in   (req_wdata),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
  );

  sram_rd_capture #(
    .DATA_W (DATA_W)
  ) i_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  p_accept_leaves_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !mem_sel_n));

  p_no_rdv_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !req_ready);

endmodule

// File: tb/test_sram_strobe_ctrl.sv
`timescale 1ns/1ps
module test_sram_strobe_ctrl;

  localparam int CLK_PS = 5000;
  // fast-grade expectations computed from the nanosecond minimums
  localparam int ACC   = (70 * 1000 + CLK_PS - 1) / CLK_PS;          // 14
  localparam int PW    = (50 * 1000 + CLK_PS - 1) / CLK_PS;          // 10
  localparam int DS    = (30 * 1000 + CLK_PS - 1) / CLK_PS;          // 6
  localparam int AWC   = (60 * 1000 + CLK_PS - 1) / CLK_PS;          // 12
  localparam int WCC   = (70 * 1000 + CLK_PS - 1) / CLK_PS;          // 14
  localparam int TURN  = (25 * 1000 + CLK_PS - 1) / CLK_PS;          // 5
  localparam int P1    = (PW > DS) ? PW : DS;
  localparam int P     = (P1 > AWC - 1) ? P1 : AWC - 1;              // 11
  localparam int REC   = (WCC - 1 - P > 1) ? WCC - 1 - P : 1;        // 2

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic [17:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int n_tot = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  sram_strobe_ctrl i_sram_strobe_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tot++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- RAM model and pin monitor (all at negedge) ----------
  logic [7:0] mem_m [256];
  int  rd_age = 0, we_run = 0, sel_age = 0, sel_at_we = 0, dq_run = 0;
  int  oe_gap = 1000, clash = 0, addr_viol = 0, dq_viol = 0;
  bit  we_prev_low = 0, dq_prev = 0, sel_prev = 0;
  logic [7:0]  wr_hold;
  logic [17:0] addr_prev;

  // data becomes valid only after the access time has elapsed
  assign mem_dq_in = (rd_age >= ACC) ? mem_m[mem_addr[7:0]] : ~mem_m[mem_addr[7:0]];

  always @(negedge clk) begin
    if (rst_n) begin
      bit sel_act;
      sel_act = !mem_sel_n && mem_sel;
      if (!mem_oe_n && sel_act && mem_we_n) rd_age++; else rd_age = 0;
      if (sel_act) sel_age++; else sel_age = 0;
      if (mem_dq_oe && !mem_oe_n) clash++;
      if (mem_dq_oe && !sel_act) dq_viol++;
      if (sel_act && sel_prev && mem_addr != addr_prev) addr_viol++;
      // R5: turnaround between output enable release and bus drive
      if (mem_dq_oe && !dq_prev)
        chk(oe_gap >= TURN, "R5 turnaround", oe_gap, TURN);
      if (!mem_oe_n) oe_gap = 0; else if (oe_gap < 1000) oe_gap++;
      if (!mem_we_n) begin
        if (!mem_dq_oe) dq_viol++;
        if (we_prev_low && mem_dq_out != wr_hold) dq_viol++;
        wr_hold = mem_dq_out;
        we_run++;
        sel_at_we = sel_age;
      end else if (we_prev_low) begin
        chk(we_run == P, "R3 pulse width", we_run, P);
        chk(sel_at_we >= AWC, "R3 select to end of write", sel_at_we, AWC);
        mem_m[mem_addr[7:0]] = wr_hold;
        we_run = 0;
      end
      if (mem_dq_oe) dq_run++;
      else if (dq_prev) begin
        chk(dq_run == P + REC, "R4 drive length", dq_run, P + REC);
        dq_run = 0;
      end
      we_prev_low = !mem_we_n;
      dq_prev     = mem_dq_oe;
      sel_prev    = sel_act;
      addr_prev   = mem_addr;
    end
  end

  // ---------------- host tasks ----------------
  function automatic logic [17:0] addr_of(input int i);
    return {i[7:0], 2'b10, i[7:0]};
  endfunction

  task automatic do_write(input int i, input logic [7:0] d);
    int n, pulses;
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = addr_of(i); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!mem_sel_n && mem_sel && mem_we_n && !mem_dq_oe, "R3 setup cycle", mem_we_n, 1);
    n = 0; pulses = 0;
    while (!req_ready) begin
      @(negedge clk); n++;
      if (rd_valid) pulses++;
    end
    chk(n == 1 + P + REC, "R3 write length", n, 1 + P + REC);
    chk(pulses == 0, "R8 no valid on write", pulses, 0);
  endtask

  task automatic do_read(input int i, input logic [7:0] exp);
    int n, pulses, pos;
    logic [7:0] got;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = addr_of(i);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!mem_sel_n && mem_sel && mem_we_n && !mem_oe_n, "R2 read strobes", mem_oe_n, 0);
    chk(mem_addr == addr_of(i), "R6 address", mem_addr, addr_of(i));
    n = 0; pulses = 0; pos = 0; got = 0;
    while (!req_ready) begin
      @(negedge clk); n++;
      if (rd_valid) begin pulses++; pos = n; got = rd_data; end
    end
    chk(n == ACC + TURN, "R5 read length", n, ACC + TURN);
    chk(pulses == 1 && pos == ACC, "R8 valid pulse position", pos, ACC);
    chk(got == exp, "R2 read data", got, exp);
  endtask

  // R7: a write held valid from the cycle after a read is accepted
  task automatic busy_overlap(input int a, input logic [7:0] ea, input int b, input logic [7:0] db);
    int n, early, held;
    logic [7:0] got;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = addr_of(a);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1; req_addr = addr_of(b); req_wdata = db;
    n = 0; early = 0; held = 0; got = 0;
    while (!req_ready) begin
      if (mem_addr != addr_of(a)) held++;
      @(negedge clk); n++;
      if (rd_valid) got = rd_data;
    end
    chk(held == 0, "R7 busy request ignored", held, 0);
    chk(got == ea, "R7 read data kept", got, ea);
    @(negedge clk);
    chk(!req_ready && mem_addr == addr_of(b), "R7 taken after ready", mem_addr, addr_of(b));
    req_valid = 0;
    while (!req_ready) @(negedge clk);
    do_read(b, db);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 11);
  endfunction

  initial begin
    for (int k = 0; k < 256; k++) mem_m[k] = 8'h00;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid && req_ready,
        "R1 in reset", 0, 1);
    rst_n = 1;
    @(negedge clk);
    chk(mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid && req_ready,
        "R1 after reset", 0, 1);
    // full sweep: write all, then read all
    for (int i = 0; i < 256; i++) do_write(i, pat(i));
    for (int i = 0; i < 256; i++) do_read(i, pat(i));
    // interleaved read-then-write-then-read
    for (int i = 0; i < 64; i++) begin
      do_read(i, pat(i));
      do_write(i, pat(i) ^ 8'h5A);
      do_read(i, pat(i) ^ 8'h5A);
    end
    busy_overlap(100, pat(100), 200, 8'hC3);
    busy_overlap(7, pat(7) ^ 8'h5A, 8, 8'h3C);
    repeat (4) @(negedge clk);
    chk(clash == 0, "R5 bus clash", clash, 0);
    chk(addr_viol == 0, "R6 address moved", addr_viol, 0);
    chk(dq_viol == 0, "R4 drive outside write", dq_viol, 0);
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

endmodule